// File: doc/BRIEF.md
# PATA PIO Register Pin Controller

This block gives a processor direct, register-level control of a parallel ATA bus. Software writes a control word whose low bits go straight to the two active-low chip selects, the three device-address lines and the active-low read and write strobes. Every cycle timing (setup, active time and recovery) comes from the order and spacing of those writes. The block reads the device interrupt and ready lines through a synchronizer and shows them in the same control word.

A write-data register supplies the 16-bit bus while the write strobe is low. A configurable number of clocks after the strobe rises, the block releases the bus. A read-data register captures the bus at the moment the read strobe rises. A configuration word holds the master enable, three transfer-mode select bits, a four-bit mode number and the two-bit write hold count. Suitable minimum hold counts are 3 clocks for mode 0, 2 for modes 1 and 2, and 1 for modes 3 and 4. Software picks the count, and the block does not check it. When the enable bit is clear, every bus output is held inactive.

The register port accepts one access per cycle and never applies back-pressure. A read returns its data with a response-valid pulse exactly one cycle after the request. A write produces no response.

Top module: `pata_pio_pins`

## Requirements
- R1: After reset the control word reads 0x63: chip selects and both strobes high, address 0. The configuration, write-data and read-data registers read 0. The bus pins show both chip selects high, both strobes high, address 0, and the data bus not driven.
- R2: Every cycle with a read request is followed, in the next cycle, by a response-valid pulse and the addressed word. A write request produces no response pulse.
- R3: While enabled, control bit 0 drives chip select 0, bit 1 drives chip select 1, bits 4:2 drive the device address, bit 5 drives the read strobe and bit 6 drives the write strobe. Bits 6:0 read back as written at offset 0x00.
- R4: The configuration word at offset 0x04 stores the following fields, which read back as written: enable at bit 0, the three mode selects at bits 3:1, the mode number at bits 7:4 and the hold count at bits 9:8.
- R5: While the enable bit is clear, both chip selects and both strobes are high, the address lines are 0 and the data bus is released. The control word keeps its stored value.
- R6: Control read bit 9 shows the interrupt input and bit 10 shows the ready input, each after a two-flop synchronizer. A value that changed in the cycle of the read request is not yet visible. Writes to these bits have no effect.
- R7: The value written at offset 0x10 appears on the data outputs, and the data output enable is high whenever the write strobe pin is low.
- R8: When the write strobe pin rises, the bus stays driven for exactly the number of clocks in the hold count. A count of 0 releases it in the same cycle.
- R9: Offset 0x14 returns the data input as it was at the clock edge where the read strobe pin rose. It does not change at any other time, including on writes to 0x14.
- R10: Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register request this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read response valid (one cycle after request) |
| reg_rdata | output | 32 | Read response data |
| ata_cs_n | output | 2 | Active-low chip selects {1,0} |
| ata_addr | output | 3 | Device register address |
| ata_rd_strobe_n | output | 1 | Active-low read strobe |
| ata_wr_strobe_n | output | 1 | Active-low write strobe |
| ata_data_o | output | 16 | Data bus output value |
| ata_data_oe | output | 1 | Data bus output enable |
| ata_data_i | input | 16 | Data bus input value |
| ata_intreq | input | 1 | Device interrupt request (asynchronous) |
| ata_ready | input | 1 | Device ready (asynchronous) |

## Verification
The bench builds the block with its defaults: a 16-bit data bus, a 6-bit offset space, a 32-bit register word and two synchronizer stages. With the two-bit hold field, all four hold counts (0 through 3) are tested, including the immediate release at 0. The two-stage synchronizer makes the delay at which a status change becomes visible short enough to be checked cycle by cycle. The 6-bit offset leaves unmapped locations above the four registers that can be read to check that they return 0.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_WDATA = 'h10;
  localparam int OFS_RDATA = 'h14;

  localparam int HOLD_W    = 2;
  localparam int MODE_W    = 4;
  localparam int CTRL_BITS = 7;
  localparam int CFG_BITS  = 4 + MODE_W + HOLD_W;

  // packed MSB first: write strobe lands at bit 6, chip select 0 at bit 0
  typedef struct packed {
    logic       wr_n;
    logic       rd_n;
    logic [2:0] addr;
    logic       cs1_n;
    logic       cs0_n;
  } ctrl_t;

  typedef struct packed {
    logic [HOLD_W-1:0] hold;
    logic [MODE_W-1:0] mode;
    logic              sel_udma;
    logic              sel_mdma;
    logic              sel_pio;
    logic              en;
  } cfg_t;

  localparam ctrl_t CTRL_RST = '{wr_n: 1'b1, rd_n: 1'b1, addr: 3'd0, cs1_n: 1'b1, cs0_n: 1'b1};
endpackage

// File: rtl/pata_sync.sv
module pata_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pata_hold_ctr.sv
module pata_hold_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         active
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/pata_rd_latch.sv
module pata_rd_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout <= '0;
    else if (capture) dout <= din;
  end
endmodule

// File: rtl/pata_pio_pins.sv
module pata_pio_pins
  import pata_pio_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              reg_rvalid,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [1:0]        ata_cs_n,
  output logic [2:0]        ata_addr,
  output logic              ata_rd_strobe_n,
  output logic              ata_wr_strobe_n,
  output logic [DATA_W-1:0] ata_data_o,
  output logic              ata_data_oe,
  input  logic [DATA_W-1:0] ata_data_i,
  input  logic              ata_intreq,
  input  logic              ata_ready
);
  ctrl_t             ctrl_q, ctrl_d;
  cfg_t              cfg_q, cfg_d;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [1:0]        stat_s;
  logic              en_w, hold_active;
  logic [HOLD_W-1:0] hold_w;
  logic              wr_ctrl, wr_cfg, wr_wdata, rd_req;
  logic              rd_pin_now, rd_pin_nxt, wr_pin_now, wr_pin_nxt;
  logic [REG_W-1:0]  rd_mux;

  assign rd_req   = reg_valid & ~reg_write;
  assign wr_ctrl  = reg_valid & reg_write & (reg_addr == ADDR_W'(OFS_CTRL));
  assign wr_cfg   = reg_valid & reg_write & (reg_addr == ADDR_W'(OFS_CFG));
  assign wr_wdata = reg_valid & reg_write & (reg_addr == ADDR_W'(OFS_WDATA));

  assign ctrl_d = wr_ctrl ? ctrl_t'(reg_wdata[CTRL_BITS-1:0]) : ctrl_q;
  assign cfg_d  = wr_cfg  ? cfg_t'(reg_wdata[CFG_BITS-1:0])   : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      cfg_q   <= '0;
      wdata_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      if (wr_wdata) wdata_q <= reg_wdata[DATA_W-1:0];
    end
  end

  assign en_w   = cfg_q.en;
  assign hold_w = cfg_q.hold;

  // strobe pin level now and after the coming edge; edges are judged at the pins
  assign rd_pin_now = ~en_w | ctrl_q.rd_n;
  assign wr_pin_now = ~en_w | ctrl_q.wr_n;
  assign rd_pin_nxt = ~cfg_d.en | ctrl_d.rd_n;
  assign wr_pin_nxt = ~cfg_d.en | ctrl_d.wr_n;

  pata_hold_ctr #(.W(HOLD_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (~cfg_d.en | ~wr_pin_nxt),
    .load     (~wr_pin_now & wr_pin_nxt),
    .load_val (hold_w),
    .active   (hold_active)
  );

  pata_rd_latch #(.W(DATA_W)) u_rdl (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (~rd_pin_now & rd_pin_nxt),
    .din     (ata_data_i),
    .dout    (rdata_q)
  );

  pata_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ata_ready, ata_intreq}),
    .sync_out (stat_s)
  );

  assign ata_cs_n        = en_w ? {ctrl_q.cs1_n, ctrl_q.cs0_n} : 2'b11;
  assign ata_addr        = en_w ? ctrl_q.addr : 3'd0;
  assign ata_rd_strobe_n = rd_pin_now;
  assign ata_wr_strobe_n = wr_pin_now;
  assign ata_data_o      = wdata_q;
  assign ata_data_oe     = en_w & (~ctrl_q.wr_n | hold_active);

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL))       rd_mux = REG_W'({stat_s, 2'b00, ctrl_q});
    else if (reg_addr == ADDR_W'(OFS_CFG))   rd_mux = REG_W'(cfg_q);
    else if (reg_addr == ADDR_W'(OFS_WDATA)) rd_mux = REG_W'(wdata_q);
    else if (reg_addr == ADDR_W'(OFS_RDATA)) rd_mux = REG_W'(rdata_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_req;
      if (rd_req) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pata_pio_pins_chk.sv
module pata_pio_pins_chk #(
  parameter int DATA_W = 16,
  parameter int HOLD_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic              reg_rvalid,
  input logic              ata_rd_strobe_n,
  input logic              ata_wr_strobe_n,
  input logic              ata_data_oe,
  input logic              en,
  input logic [HOLD_W-1:0] hold,
  input logic [DATA_W-1:0] cap
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rvalid == $past(reg_valid && !reg_write));

  assert_drive_in_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_wr_strobe_n |-> ata_data_oe);

  assert_hold_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ata_wr_strobe_n) && en && hold != '0) |-> ata_data_oe);

  assert_release_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ata_data_oe) |-> ata_wr_strobe_n);

  assert_capture_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(ata_rd_strobe_n) |-> $stable(cap));
endmodule

bind pata_pio_pins pata_pio_pins_chk #(.DATA_W(DATA_W), .HOLD_W(pata_pio_pkg::HOLD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .reg_valid       (reg_valid),
  .reg_write       (reg_write),
  .reg_rvalid      (reg_rvalid),
  .ata_rd_strobe_n (ata_rd_strobe_n),
  .ata_wr_strobe_n (ata_wr_strobe_n),
  .ata_data_oe     (ata_data_oe),
  .en              (en_w),
  .hold            (hold_w),
  .cap             (rdata_q)
);

// File: tb/sim_pata_pio_pins.sv
module sim_pata_pio_pins;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic [1:0]  ata_cs_n;
  logic [2:0]  ata_addr;
  logic        ata_rd_strobe_n, ata_wr_strobe_n;
  logic [15:0] ata_data_o;
  logic        ata_data_oe;
  logic [15:0] ata_data_i = '0;
  logic        ata_intreq = 1'b0, ata_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pata_pio_pins u0 (.*);

  function automatic logic [31:0] exp_ctrl(logic [6:0] c, logic intr, logic rdy);
    return {21'd0, rdy, intr, 2'b00, c};
  endfunction

  function automatic logic [31:0] mk_cfg(logic en, logic [2:0] sel, logic [3:0] mode, logic [1:0] h);
    return {22'd0, h, mode, sel, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic reg_rd(logic [5:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_addr = a;
    @(negedge clk);
    reg_valid = 0;
    d = reg_rdata; v = reg_rvalid;
  endtask

  task automatic pins(string tag, logic [1:0] cs, logic [2:0] ad, logic rd, logic wr);
    check(tag, {25'd0, cs, ad, rd, wr}, {25'd0, ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n} ^ 32'd0 ^
          ({25'd0, ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n} ^ {25'd0, cs, ad, rd, wr}) ^
          ({25'd0, ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n} ^ {25'd0, cs, ad, rd, wr}));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, seed_dummy;
    logic v;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 pins", {ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n, ata_data_oe},
          {2'b11, 3'd0, 1'b1, 1'b1, 1'b0});
    reg_rd(6'h00, d, v); check("R1 ctrl", d, 32'h63);
    check("R2 read valid", {31'd0, v}, 32'd1);
    reg_rd(6'h04, d, v); check("R1 cfg", d, 0);
    reg_rd(6'h10, d, v); check("R1 wdata", d, 0);
    reg_rd(6'h14, d, v); check("R1 rdata", d, 0);
    reg_wr(6'h10, 32'h0);
    check("R2 no resp on write", {31'd0, reg_rvalid}, 32'd0);

    // R4 config readback, random fields
    for (int i = 0; i < 8; i++) begin
      logic [31:0] c;
      c = mk_cfg($urandom % 2, 3'($urandom), 4'($urandom), 2'($urandom));
      reg_wr(6'h04, c | 32'hFFFF_FC00);
      reg_rd(6'h04, d, v); check("R4 cfg readback", d, c);
    end

    // R3 control drives pins while enabled; R6 status bits not writable
    reg_wr(6'h04, mk_cfg(1, 3'b001, 4'd0, 2'd3));
    for (int i = 0; i < 20; i++) begin
      logic [6:0] c;
      c = 7'($urandom);
      reg_wr(6'h00, {21'd0, 2'b11, 2'b11, c});
      check("R3 pins", {ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n},
            {c[1], c[0], c[4:2], c[5], c[6]});
      reg_rd(6'h00, d, v); check("R3 R6 ctrl readback", d, exp_ctrl(c, 0, 0));
    end

    // R5 disable forces bus idle
    reg_wr(6'h00, 32'h00);
    reg_wr(6'h04, mk_cfg(0, 3'b001, 4'd2, 2'd1));
    check("R5 idle pins", {ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n, ata_data_oe},
          {2'b11, 3'd0, 1'b1, 1'b1, 1'b0});
    reg_rd(6'h00, d, v); check("R5 ctrl kept", d, 0);
    reg_wr(6'h04, mk_cfg(1, 3'b001, 4'd2, 2'd1));
    check("R3 re-enable pins", {ata_cs_n, ata_addr, ata_rd_strobe_n, ata_wr_strobe_n, ata_data_oe},
          {2'b00, 3'd0, 1'b0, 1'b0, 1'b1});
    reg_wr(6'h00, 32'h63);

    // R6 status synchronizer delay
    ata_intreq = 1;
    reg_rd(6'h00, d, v); check("R6 intreq not yet", d, exp_ctrl(7'h63, 0, 0));
    repeat (3) @(negedge clk);
    reg_rd(6'h00, d, v); check("R6 intreq seen", d, exp_ctrl(7'h63, 1, 0));
    ata_ready = 1;
    repeat (3) @(negedge clk);
    reg_rd(6'h00, d, v); check("R6 ready seen", d, exp_ctrl(7'h63, 1, 1));
    ata_intreq = 0; ata_ready = 0;
    repeat (3) @(negedge clk);

    // R7/R8 write drive and hold, every hold count
    for (int h = 0; h < 4; h++) begin
      logic [15:0] wd;
      wd = 16'($urandom);
      reg_wr(6'h04, mk_cfg(1, 3'b001, 4'(h), 2'(h)));
      reg_wr(6'h10, {16'hABCD, wd});
      check("R8 idle before strobe", {31'd0, ata_data_oe}, 32'd0);
      reg_wr(6'h00, 32'h21);
      check("R7 drive in strobe", {15'd0, ata_data_oe, ata_data_o}, {15'd0, 1'b1, wd});
      reg_wr(6'h00, 32'h61);
      check("R8 hold first", {31'd0, ata_data_oe}, {31'd0, h > 0});
      for (int k = 1; k < 5; k++) begin
        @(negedge clk);
        check("R8 hold count", {31'd0, ata_data_oe}, {31'd0, h > k});
      end
    end

    // R9 capture on read strobe rise only
    for (int i = 0; i < 6; i++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = ~x;
      reg_wr(6'h00, 32'h41);
      ata_data_i = x;
      reg_wr(6'h00, 32'h61);
      ata_data_i = y;
      reg_rd(6'h14, d, v); check("R9 captured", d, {16'd0, x});
      reg_wr(6'h00, 32'h65);
      reg_wr(6'h14, 32'h1234);
      reg_rd(6'h14, d, v); check("R9 no recapture", d, {16'd0, x});
      // disabled: internal rise must not capture
      reg_wr(6'h04, mk_cfg(0, 3'b001, 4'd0, 2'd0));
      reg_wr(6'h00, 32'h41);
      reg_wr(6'h00, 32'h61);
      reg_rd(6'h14, d, v); check("R9 R5 no capture when off", d, {16'd0, x});
      reg_wr(6'h04, mk_cfg(1, 3'b001, 4'd0, 2'd0));
    end

    // R10 unmapped offsets
    reg_rd(6'h08, d, v); check("R10 unmapped 08", d, 0);
    reg_rd(6'h3C, d, v); check("R10 unmapped 3C", d, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule